// File: doc/BRIEF.md
# Dual-Channel Prescaled Down-Counting Timer

This block holds two independent down-counters behind a small synchronous register port. Each channel has a control word, a reload value and a readable live count. The channel's clock enable comes from its own prescaler, which passes one tick every (prescale + 1) cycles. The counter starts from the reload value and moves down by one on each tick. When the count runs out, the channel sets its bit in a shared expiry status word. A one-shot channel then stops at zero and clears its own enable. A periodic channel loads the reload value again and carries on.

Software typically uses one channel as a periodic or one-shot event source with its interrupt enabled. The other channel is set up as a periodic counter with an all-ones reload, and software reads the live count inverted to get a rising timestamp. Expiry flags are cleared by writing ones to the status word. Each channel drives its own registered interrupt line. That line is high while the channel's flag and its interrupt enable are both set.

Top module: `dual_tick_timer`

## Requirements
- R1: After reset, every control, reload, count and status value reads as zero, `rdata` is zero and both `irq` lines are low.
- R2: Control word layout: prescale in bits 7:0, mode in bits 28:27 (01 periodic, every other code one-shot), interrupt enable in bit 29, counter enable in bit 30. The control word reads back exactly these fields, and every other bit reads 0.
- R3: While enabled, the count falls by one every (prescale + 1) clock cycles. With reload N (N at least 1), the flag is set on the edge N*(prescale+1) cycles after the counter is armed.
- R4: A control write that moves enable from 0 to 1 loads the count from the reload register. A control write to a channel that is already enabled does not reload the count. Every control or reload write to a channel restarts its prescale phase, and any tick due in that cycle is dropped.
- R5: Expiry happens on the tick where the count is 1 or 0. A one-shot channel then shows count 0 and enable bit 0.
- R6: A periodic channel loads the count from the reload register on each expiry and keeps running. In periodic mode, a reload write only stores the value: it neither arms the channel nor changes the live count.
- R7: In one-shot mode, a reload write stores the value, loads it into the count and sets the enable bit. This starts a fresh single countdown.
- R8: The status word (address low bits 11) holds channel i's flag in bit i. Writing a 1 to a bit clears that flag. Zero bits and bits above the channel count have no effect.
- R9: When an expiry and a clearing write hit the same flag in the same cycle, the flag stays set.
- R10: `irq[i]` is registered and equals flag i AND interrupt-enable i after every edge, including right after a control write that changes the interrupt enable.
- R11: Writing zero to a control word stops the channel. Its count holds its value and it raises no new expiry.
- R12: The address is {channel, select}: select 00 is control, 01 reload, 10 count and 11 status. `rdata` is loaded on the edge where `rd_en` is high and holds its value otherwise.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for all registers and for the prescalers |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe; `rdata` updates on the next edge |
| addr | input | ADDR_W (3) | {channel index, 2-bit register select} |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Registered read data |
| irq | output | NCH (2) | Per-channel interrupt, flag AND interrupt enable |

## Verification
Two events can land in the same cycle: a channel's expiry setting its flag, and a status write clearing that same flag. The bench runs a periodic channel with a short, known period. It counts cycles from the last expiry and issues the clearing write on exactly the edge of the next expiry. A status read that follows must still show the flag set. Clears issued on other edges must drop the flag, and this gives the contrast.

// File: rtl/dtt_pkg.sv
package dtt_pkg;
  localparam int WORD_W   = 32;
  localparam int MODE_LSB = 27;
  localparam int IE_BIT   = 29;
  localparam int EN_BIT   = 30;

  // Mode code that keeps the channel running; all others stop after expiry.
  localparam logic [1:0] MODE_REPEAT = 2'b01;

  typedef enum logic [1:0] {
    SEL_CTRL   = 2'd0,
    SEL_RELOAD = 2'd1,
    SEL_COUNT  = 2'd2,
    SEL_STATUS = 2'd3
  } reg_sel_e;

  typedef struct packed {
    logic       en;
    logic       ie;
    logic [1:0] mode;
  } ctrl_bits_t;
endpackage

// File: rtl/dtt_prescaler.sv
module dtt_prescaler #(
  parameter int PRE_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic             restart,
  input  logic [PRE_W-1:0] divide,
  output logic             tick
);
  logic [PRE_W-1:0] phase_q;
  logic             at_end;

  assign at_end = (phase_q == divide);
  // A restart cycle never produces a tick (R4).
  assign tick   = run & ~restart & at_end;

  always_ff @(posedge clk) begin
    if (rst || restart || !run) phase_q <= '0;
    else if (at_end)            phase_q <= '0;
    else                        phase_q <= phase_q + 1'b1;
  end
endmodule

// File: rtl/dtt_channel.sv
module dtt_channel
  import dtt_pkg::*;
#(
  parameter int CNT_W = 32,
  parameter int PRE_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ctrl_we,
  input  logic              reload_we,
  input  logic [WORD_W-1:0] wdata,
  output ctrl_bits_t        ctrl_q,
  output logic              ie_next,
  output logic              periodic,
  output logic [PRE_W-1:0]  pre_q,
  output logic [CNT_W-1:0]  reload_q,
  output logic [CNT_W-1:0]  count_q,
  output logic              expire,
  output logic [WORD_W-1:0] ctrl_word
);
  logic restart;
  logic tick;
  logic start_ctrl;
  logic arm_reload;

  assign periodic   = (ctrl_q.mode == MODE_REPEAT);
  assign restart    = ctrl_we | reload_we;
  assign start_ctrl = ctrl_we & wdata[EN_BIT] & ~ctrl_q.en;
  assign arm_reload = reload_we & ~periodic;
  assign ie_next    = ctrl_we ? wdata[IE_BIT] : ctrl_q.ie;
  assign expire     = tick & (count_q <= CNT_W'(1));

  dtt_prescaler #(.PRE_W(PRE_W)) u_pre (
    .clk     (clk),
    .rst     (rst),
    .run     (ctrl_q.en),
    .restart (restart),
    .divide  (pre_q),
    .tick    (tick)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q   <= '0;
      pre_q    <= '0;
      reload_q <= '0;
      count_q  <= '0;
    end else if (ctrl_we) begin
      ctrl_q.en   <= wdata[EN_BIT];
      ctrl_q.ie   <= wdata[IE_BIT];
      ctrl_q.mode <= wdata[MODE_LSB +: 2];
      pre_q       <= wdata[PRE_W-1:0];
      if (start_ctrl) count_q <= reload_q;
    end else if (reload_we) begin
      reload_q <= wdata[CNT_W-1:0];
      if (arm_reload) begin
        count_q   <= wdata[CNT_W-1:0];
        ctrl_q.en <= 1'b1;
      end
    end else if (tick) begin
      if (expire) begin
        if (periodic) begin
          count_q <= reload_q;
        end else begin
          count_q   <= '0;
          ctrl_q.en <= 1'b0;
        end
      end else begin
        count_q <= count_q - 1'b1;
      end
    end
  end

  always_comb begin
    ctrl_word                     = '0;
    ctrl_word[EN_BIT]             = ctrl_q.en;
    ctrl_word[IE_BIT]             = ctrl_q.ie;
    ctrl_word[MODE_LSB +: 2]      = ctrl_q.mode;
    ctrl_word[PRE_W-1:0]          = pre_q;
  end
endmodule

// File: rtl/dtt_status.sv
module dtt_status #(
  parameter int NCH = 2
) (
  input  logic           clk,
  input  logic           rst,
  input  logic [NCH-1:0] set,
  input  logic           clr_we,
  input  logic [NCH-1:0] clr_bits,
  input  logic [NCH-1:0] ie_next,
  output logic [NCH-1:0] flag_q,
  output logic [NCH-1:0] irq_q
);
  logic [NCH-1:0] clr_eff;
  logic [NCH-1:0] flag_d;

  assign clr_eff = clr_we ? clr_bits : '0;
  // Set is OR-ed last so it wins over a same-cycle clear (R9).
  assign flag_d  = set | (flag_q & ~clr_eff);

  always_ff @(posedge clk) begin
    if (rst) begin
      flag_q <= '0;
      irq_q  <= '0;
    end else begin
      flag_q <= flag_d;
      irq_q  <= flag_d & ie_next;
    end
  end
endmodule

// File: rtl/dual_tick_timer.sv
module dual_tick_timer
  import dtt_pkg::*;
#(
  parameter  int NCH    = 2,
  parameter  int CNT_W  = 32,
  parameter  int PRE_W  = 8,
  localparam int CH_W   = (NCH > 1) ? $clog2(NCH) : 1,
  localparam int ADDR_W = CH_W + 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [WORD_W-1:0] wdata,
  output logic [WORD_W-1:0] rdata,
  output logic [NCH-1:0]    irq
);
  reg_sel_e                     sel;
  logic [CH_W-1:0]              ch_idx;
  logic [NCH-1:0]               ctrl_we;
  logic [NCH-1:0]               reload_we;
  logic                         stat_we;
  logic [NCH-1:0]               expire_v;
  logic [NCH-1:0]               ie_next_v;
  logic [NCH-1:0]               en_v;
  logic [NCH-1:0]               ie_v;
  logic [NCH-1:0]               periodic_v;
  logic [NCH-1:0]               flag_v;
  logic [NCH-1:0][WORD_W-1:0]   ctrl_v;
  logic [NCH-1:0][CNT_W-1:0]    count_v;
  logic [NCH-1:0][CNT_W-1:0]    reload_v;
  logic [WORD_W-1:0]            rd_word;

  assign sel     = reg_sel_e'(addr[1:0]);
  assign ch_idx  = addr[ADDR_W-1:2];
  assign stat_we = wr_en && (sel == SEL_STATUS);

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    ctrl_bits_t      cb;
    logic [PRE_W-1:0] pre;

    assign ctrl_we[g]   = wr_en && (sel == SEL_CTRL)   && (ch_idx == CH_W'(g));
    assign reload_we[g] = wr_en && (sel == SEL_RELOAD) && (ch_idx == CH_W'(g));

    dtt_channel #(.CNT_W(CNT_W), .PRE_W(PRE_W)) u_chan (
      .clk       (clk),
      .rst       (rst),
      .ctrl_we   (ctrl_we[g]),
      .reload_we (reload_we[g]),
      .wdata     (wdata),
      .ctrl_q    (cb),
      .ie_next   (ie_next_v[g]),
      .periodic  (periodic_v[g]),
      .pre_q     (pre),
      .reload_q  (reload_v[g]),
      .count_q   (count_v[g]),
      .expire    (expire_v[g]),
      .ctrl_word (ctrl_v[g])
    );

    assign en_v[g] = cb.en;
    assign ie_v[g] = cb.ie;
  end

  dtt_status #(.NCH(NCH)) u_status (
    .clk      (clk),
    .rst      (rst),
    .set      (expire_v),
    .clr_we   (stat_we),
    .clr_bits (wdata[NCH-1:0]),
    .ie_next  (ie_next_v),
    .flag_q   (flag_v),
    .irq_q    (irq)
  );

  always_comb begin
    rd_word = '0;
    if (sel == SEL_STATUS) begin
      rd_word = WORD_W'(flag_v);
    end else if (int'(ch_idx) < NCH) begin
      case (sel)
        SEL_CTRL:   rd_word = ctrl_v[ch_idx];
        SEL_RELOAD: rd_word = WORD_W'(reload_v[ch_idx]);
        SEL_COUNT:  rd_word = WORD_W'(count_v[ch_idx]);
        default:    rd_word = '0;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst)        rdata <= '0;
    else if (rd_en) rdata <= rd_word;
  end
endmodule

// File: rtl/dtt_checker.sv
module dtt_checker #(
  parameter int NCH   = 2,
  parameter int CNT_W = 32
) (
  input logic                     clk,
  input logic                     rst,
  input logic                     stat_we,
  input logic [NCH-1:0]           clr_bits,
  input logic [NCH-1:0]           ctrl_we,
  input logic [NCH-1:0]           reload_we,
  input logic [NCH-1:0]           expire,
  input logic [NCH-1:0]           flag,
  input logic [NCH-1:0]           irq,
  input logic [NCH-1:0]           en,
  input logic [NCH-1:0]           ie,
  input logic [NCH-1:0]           periodic,
  input logic [NCH-1:0][CNT_W-1:0] count,
  input logic [NCH-1:0][CNT_W-1:0] reload
);
  for (genvar i = 0; i < NCH; i++) begin : g_chk
    a_r9_set_wins: assert property (@(posedge clk) disable iff (rst)
      expire[i] |=> flag[i]);

    a_r8_clear_by_write: assert property (@(posedge clk) disable iff (rst)
      $fell(flag[i]) |-> $past(stat_we && clr_bits[i]));

    a_r10_irq_gate: assert property (@(posedge clk) disable iff (rst)
      irq[i] == (flag[i] && ie[i]));

    a_r5_oneshot_stop: assert property (@(posedge clk) disable iff (rst)
      (expire[i] && !periodic[i]) |=> (!en[i] && count[i] == '0));

    a_r6_periodic_reload: assert property (@(posedge clk) disable iff (rst)
      (expire[i] && periodic[i]) |=> (count[i] == $past(reload[i])));

    a_r11_idle_hold: assert property (@(posedge clk) disable iff (rst)
      (!en[i] && !ctrl_we[i] && !reload_we[i]) |=> $stable(count[i]));
  end
endmodule

bind dual_tick_timer dtt_checker #(.NCH(NCH), .CNT_W(CNT_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .stat_we   (stat_we),
  .clr_bits  (wdata[NCH-1:0]),
  .ctrl_we   (ctrl_we),
  .reload_we (reload_we),
  .expire    (expire_v),
  .flag      (flag_v),
  .irq       (irq),
  .en        (en_v),
  .ie        (ie_v),
  .periodic  (periodic_v),
  .count     (count_v),
  .reload    (reload_v)
);

// File: tb/test_dual_tick_timer.sv
module test_dual_tick_timer;
  localparam int NCH    = 2;
  localparam int ADDR_W = 3;
  localparam logic [31:0] IE  = 32'h2000_0000;
  localparam logic [31:0] EN  = 32'h4000_0000;
  localparam logic [31:0] REP = 32'h0800_0000;

  logic              clk = 1'b0;
  logic              rst;
  logic              wr_en, rd_en;
  logic [ADDR_W-1:0] addr;
  logic [31:0]       wdata;
  logic [31:0]       rdata;
  logic [NCH-1:0]    irq;

  int cyc = 0;
  int checks = 0;
  int errors = 0;
  bit done = 0;

  dual_tick_timer #(.NCH(NCH), .CNT_W(32), .PRE_W(8)) i_dual_tick_timer (
    .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en),
    .addr(addr), .wdata(wdata), .rdata(rdata), .irq(irq)
  );

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Called at a negedge; the write lands on the next edge, returns at the negedge after it.
  task automatic wr_now(input logic [ADDR_W-1:0] a, input logic [31:0] d);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd_now(input logic [ADDR_W-1:0] a, output logic [31:0] d);
    rd_en = 1'b1; addr = a;
    @(negedge clk);
    rd_en = 1'b0;
    d = rdata;
  endtask

  task automatic wait_irq(input int ch, output int at);
    int n = 0;
    while (!irq[ch] && n < 3000) begin
      @(negedge clk);
      n++;
    end
    at = (n >= 3000) ? -1 : cyc;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [31:0] d, d2;
    int e, w, t1, t2, t3, t4;
    rst = 1'b1; wr_en = 1'b0; rd_en = 1'b0; addr = '0; wdata = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R1: reset state on every address
    chk("R1 irq", 32'(irq), 32'h0);
    chk("R1 rdata", rdata, 32'h0);
    for (int a = 0; a < 8; a++) begin
      rd_now(ADDR_W'(a), d);
      chk("R1 reg", d, 32'h0);
    end

    // R2: field readback; R12: rdata holds without rd_en
    wr_now(3'd4, 32'hFFFF_FFFF);
    rd_now(3'd4, d);
    chk("R2 ctrl fields", d, 32'h7800_00FF);
    wr_now(3'd4, 32'h0);
    chk("R12 rdata hold", rdata, 32'h7800_00FF);
    rd_now(3'd4, d);
    chk("R11 ctrl zero", d, 32'h0);
    wr_now(3'd3, 32'h1F);

    // R3/R5/R7: one-shot sweep, armed by reload writes
    for (int p = 0; p < 4; p++) begin
      for (int n = 1; n <= 5; n++) begin
        wr_now(3'd0, IE | 32'(p));
        wr_now(3'd1, 32'(n));
        e = cyc;
        wait_irq(0, t1);
        chk("R3 R7 expiry delay", 32'(t1 - e), 32'(n * (p + 1)));
        rd_now(3'd2, d);
        chk("R5 count zero", d, 32'h0);
        rd_now(3'd0, d);
        chk("R5 enable cleared", d, IE | 32'(p));
        wr_now(3'd3, 32'h1);
        chk("R8 clear drops irq", 32'(irq), 32'h0);
      end
    end

    // R4: control write while enabled restarts the phase, no reload
    wr_now(3'd0, IE | 32'd3);
    wr_now(3'd1, 32'd2);
    @(negedge clk);
    wr_now(3'd0, EN | IE | 32'd3);
    w = cyc;
    wait_irq(0, t1);
    chk("R4 phase restart", 32'(t1 - w), 32'd8);
    wr_now(3'd3, 32'h1);

    // R8: zero bits and high bits ignored
    wr_now(3'd0, IE);
    wr_now(3'd1, 32'd2);
    wait_irq(0, t1);
    wr_now(3'd3, 32'h0);
    rd_now(3'd3, d);
    chk("R8 zero write", d, 32'h1);
    wr_now(3'd3, 32'hFFFF_FFFC);
    rd_now(3'd3, d);
    chk("R8 high bits", d, 32'h1);
    chk("R8 irq kept", 32'(irq), 32'h1);
    wr_now(3'd3, 32'h1);
    rd_now(3'd3, d);
    chk("R8 cleared", d, 32'h0);

    // R10: flag without interrupt enable, then enable it
    wr_now(3'd0, 32'h0);
    wr_now(3'd1, 32'd2);
    repeat (5) @(negedge clk);
    chk("R10 masked irq", 32'(irq), 32'h0);
    rd_now(3'd3, d);
    chk("R10 flag set", d, 32'h1);
    wr_now(3'd0, IE);
    chk("R10 irq follows ie", 32'(irq), 32'h1);
    wr_now(3'd3, 32'h1);

    // R11: disable mid-count, count holds
    wr_now(3'd0, 32'h0);
    wr_now(3'd1, 32'd100);
    e = cyc;
    repeat (4) @(negedge clk);
    wr_now(3'd0, 32'h0);
    w = cyc;
    rd_now(3'd2, d);
    repeat (10) @(negedge clk);
    rd_now(3'd2, d2);
    chk("R11 count value", d, 32'(100 - (w - e - 1)));
    chk("R11 count held", d2, d);
    chk("R11 no irq", 32'(irq), 32'h0);

    // R6: periodic channel 1, prescale 1
    wr_now(3'd4, REP | IE | 32'd1);
    wr_now(3'd5, 32'd3);
    rd_now(3'd4, d);
    chk("R6 reload no arm", d, REP | IE | 32'd1);
    rd_now(3'd6, d);
    chk("R6 count untouched", d, 32'h0);
    wr_now(3'd4, EN | REP | IE | 32'd1);
    e = cyc;
    wait_irq(1, t1);
    chk("R4 R6 first period", 32'(t1 - e), 32'd6);
    wr_now(3'd3, 32'h2);
    wait_irq(1, t2);
    chk("R6 second period", 32'(t2 - e), 32'd12);
    wr_now(3'd3, 32'h2);
    wr_now(3'd5, 32'd1);
    w = cyc;
    wait_irq(1, t3);
    chk("R6 old reload in flight", 32'(t3 - w), 32'd6);
    wr_now(3'd3, 32'h2);
    wait_irq(1, t4);
    chk("R6 new reload", 32'(t4 - t3), 32'd2);

    // R9: clear lands on the same edge as the next expiry
    @(negedge clk);
    wr_now(3'd3, 32'h2);
    rd_now(3'd3, d);
    chk("R9 set beats clear", d, 32'h2);
    wr_now(3'd4, 32'h0);
    wr_now(3'd3, 32'h3);
    rd_now(3'd7, d);
    chk("R12 status alias", d, 32'h0);
    chk("R11 channel off irq", 32'(irq), 32'h0);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule